// File: doc/BRIEF.md
# Flash Command Status Controller

This block sits between a command source and an on-chip flash array. It takes one command byte per strobe and keeps an 8-bit status byte. The byte holds a ready flag in bit 7 and three sticky error flags: erase failure in bit 5, program failure in bit 4 and over-programmed cell in bit 3. The other bits are always zero. A built-in write state machine models the array. It holds the block busy for a cycle count taken from an input, and it takes its outcome from per-operation result inputs latched when the operation is accepted.

The controller is a three-state machine:
- ST_IDLE: ready, no error flags set.
- ST_RUN: an automatic program or erase is in progress.
- ST_LOCKED: ready, at least one error flag set.

It has four transitions:
- Start (ST_IDLE to ST_RUN): an operation command is accepted.
- Finish-clean (ST_RUN to ST_IDLE): the operation ends without error.
- Finish-error (ST_RUN to ST_LOCKED): the operation ends with an error.
- Unlock (ST_LOCKED to ST_IDLE): a clear-status command arrives.

In ST_LOCKED every operation command is refused until the clear-status command is sent. A separate read-mode flag selects whether the status byte appears on the output.

Command codes:

| Code | Command |
|------|---------|
| 0x70 | read status |
| 0x50 | clear status |
| 0xFF | leave read mode |
| 0x41 | page program |
| 0x77 | lock-bit program |
| 0x20 | block erase |
| 0xA7 | erase all unlocked blocks |

Any other code is unknown.

Top module: `flash_status_ctrl`

## Requirements
- R1: After reset the block is idle and not busy, read mode is off (status_out = 0x00), and reject is low. Once read status (0x70) has been sent, status_out reads 0x80.
- R2: Read mode behaves as follows:
  - Command 0x70 turns read mode on in any state, including while busy.
  - While read mode is on, status_out carries the status byte. While it is off, status_out is 0x00.
  - Command 0xFF turns read mode off when the block is not busy.
- R3: An accepted operation raises busy and clears status bit 7. Both take effect from the cycle after acceptance and last for max(busy_cycles,1) cycles, after which bit 7 returns to 1.
- R4: Page program (0x41) and lock-bit program (0x77) take their result from prog_result:
  - 0 gives a final status of 0x80.
  - 1 or 3 gives 0x90 (program failure).
  - 2 gives 0x88 (over-program).
- R5: Block erase (0x20) and erase-all (0xA7) take their result from erase_result. The final status is 0xA0 when erase_result bit 0 is 1 and 0x80 otherwise.
- R6: Error bits 5, 4 and 3 stay set until clear status, whatever other commands arrive and however many cycles pass.
- R7: Clear status (0x50), sent when the block is not busy, zeroes bits 5, 4 and 3 from the next cycle and leaves bit 7 at 1.
- R8: While any of bits 5, 4 or 3 is set, the four operation commands are refused: busy stays low, the status is unchanged and reject pulses.
- R9: While busy, commands 0x50, 0xFF and the four operation commands are refused with a reject pulse and have no effect. Command 0x70 is still honoured.
- R10: An unknown code changes neither the status, nor busy, nor read mode, and does not raise reject.
- R11: Status bits 6, 2, 1 and 0 are always 0.
- R12: reject is high for exactly one cycle per refused command, in the cycle after the command strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock, rising edge |
| rst_n | input | 1 | active-low asynchronous reset |
| cmd_valid | input | 1 | command strobe, one byte per cycle |
| cmd_byte | input | 8 | command code |
| busy_cycles | input | CNT_W | length of the next operation in cycles (0 treated as 1) |
| prog_result | input | 2 | program outcome: 0 pass, 2 over-program, 1/3 fail |
| erase_result | input | 2 | erase outcome: bit 0 set means fail |
| status_out | output | 8 | status byte while read mode is on, else 0x00 |
| busy | output | 1 | high while an operation runs |
| reject | output | 1 | one-cycle pulse for a refused command |

## Verification
A command strobed at one rising edge takes effect by the next cycle. In that cycle the bench expects to see:
- busy high and bit 7 low, if the command started an operation;
- the reject pulse, if it was refused;
- the new read-mode output, if it changed read mode;
- the cleared error flags, if it was clear status.

Busy is expected to stay high for exactly max(busy_cycles,1) cycles. The error flags are due in the same cycle that busy falls.

The bench drives every command on a falling edge and samples on the following falling edge. It counts busy cycles at successive falling edges and reads the final status at the first falling edge with busy low. Each check therefore lands on the cycle its result is due.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    localparam logic [7:0] OPC_READ_STAT = 8'h70;
    localparam logic [7:0] OPC_CLEAR     = 8'h50;
    localparam logic [7:0] OPC_ARRAY     = 8'hFF;
    localparam logic [7:0] OPC_PROG      = 8'h41;
    localparam logic [7:0] OPC_LOCK      = 8'h77;
    localparam logic [7:0] OPC_ERASE_BLK = 8'h20;
    localparam logic [7:0] OPC_ERASE_ALL = 8'hA7;

    typedef enum logic [2:0] {
        K_NONE,
        K_READ_STAT,
        K_CLEAR,
        K_ARRAY,
        K_PROG,
        K_LOCK,
        K_ERASE_BLK,
        K_ERASE_ALL
    } cmd_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_LOCKED
    } fsm_t;

    typedef enum logic {
        OP_PROGRAM,
        OP_ERASE
    } op_class_t;

    localparam int STAT_READY_BIT = 7;
    localparam int STAT_ERASE_BIT = 5;
    localparam int STAT_PROG_BIT  = 4;
    localparam int STAT_OVER_BIT  = 3;

endpackage

// File: rtl/fsc_cmd_decode.sv
module fsc_cmd_decode
    import fsc_pkg::*;
(
    input  logic       valid,
    input  logic [7:0] code,
    output cmd_kind_t  kind,
    output logic       is_op
);

    always_comb begin
        kind = K_NONE;
        if (valid) begin
            unique case (code)
                OPC_READ_STAT: kind = K_READ_STAT;
                OPC_CLEAR:     kind = K_CLEAR;
                OPC_ARRAY:     kind = K_ARRAY;
                OPC_PROG:      kind = K_PROG;
                OPC_LOCK:      kind = K_LOCK;
                OPC_ERASE_BLK: kind = K_ERASE_BLK;
                OPC_ERASE_ALL: kind = K_ERASE_ALL;
                default:       kind = K_NONE;
            endcase
        end
    end

    assign is_op = (kind == K_PROG) || (kind == K_LOCK) ||
                   (kind == K_ERASE_BLK) || (kind == K_ERASE_ALL);

endmodule

// File: rtl/fsc_busy_timer.sv
module fsc_busy_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    input  logic             run,
    output logic             last
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (len == '0) ? ONE : len;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign last = run && (cnt_q == ONE);

    // R3
    load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q != '0));

endmodule

// File: rtl/fsc_status_flags.sv
module fsc_status_flags
    import fsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       commit,
    input  op_class_t  op_cls,
    input  logic [1:0] result,
    input  logic       clear,
    output logic       err_erase,
    output logic       err_prog,
    output logic       err_over
);

    logic set_erase, set_prog, set_over;

    always_comb begin
        set_erase = 1'b0;
        set_prog  = 1'b0;
        set_over  = 1'b0;
        if (commit) begin
            unique case (op_cls)
                OP_ERASE:   set_erase = result[0];
                OP_PROGRAM: begin
                    set_over = (result == 2'b10);
                    set_prog = result[0];
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_erase <= 1'b0;
            err_prog  <= 1'b0;
            err_over  <= 1'b0;
        end else if (clear) begin
            err_erase <= 1'b0;
            err_prog  <= 1'b0;
            err_over  <= 1'b0;
        end else begin
            err_erase <= err_erase | set_erase;
            err_prog  <= err_prog  | set_prog;
            err_over  <= err_over  | set_over;
        end
    end

    // R7
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !(err_erase || err_prog || err_over));

    // R4
    over_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && op_cls == OP_PROGRAM && result == 2'b10) |=> (err_over && !err_prog && !err_erase));

    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && err_prog) |=> err_prog);

endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
    import fsc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_byte,
    input  logic [CNT_W-1:0] busy_cycles,
    input  logic [1:0]       prog_result,
    input  logic [1:0]       erase_result,
    output logic [7:0]       status_out,
    output logic             busy,
    output logic             reject
);

    cmd_kind_t  kind;
    logic       is_op;
    fsm_t       state_q, state_d;
    op_class_t  cls_q;
    logic [1:0] res_q;
    logic       tmr_last;
    logic       err_erase, err_prog, err_over;
    logic       rdmode_q, rdmode_d;
    logic       reject_q, reject_d;
    logic       start, clear_fire, fail_now;
    logic [7:0] stat_w;

    fsc_cmd_decode u_dec (
        .valid (cmd_valid),
        .code  (cmd_byte),
        .kind  (kind),
        .is_op (is_op)
    );

    assign start      = (state_q == ST_IDLE) && is_op;
    assign clear_fire = (kind == K_CLEAR) && (state_q != ST_RUN);
    assign fail_now   = (cls_q == OP_PROGRAM) ? (res_q != 2'b00) : res_q[0];

    fsc_busy_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start),
        .len   (busy_cycles),
        .run   (state_q == ST_RUN),
        .last  (tmr_last)
    );

    fsc_status_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (tmr_last),
        .op_cls    (cls_q),
        .result    (res_q),
        .clear     (clear_fire),
        .err_erase (err_erase),
        .err_prog  (err_prog),
        .err_over  (err_over)
    );

    // operation context latched on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cls_q <= OP_PROGRAM;
            res_q <= 2'b00;
        end else if (start) begin
            if (kind == K_ERASE_BLK || kind == K_ERASE_ALL) begin
                cls_q <= OP_ERASE;
                res_q <= erase_result;
            end else begin
                cls_q <= OP_PROGRAM;
                res_q <= prog_result;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (is_op) state_d = ST_RUN;
            ST_RUN:    if (tmr_last) state_d = fail_now ? ST_LOCKED : ST_IDLE;
            ST_LOCKED: if (kind == K_CLEAR) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output-side decisions
    always_comb begin
        rdmode_d = rdmode_q;
        reject_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (kind == K_READ_STAT) rdmode_d = 1'b1;
                if (kind == K_ARRAY)     rdmode_d = 1'b0;
            end
            ST_RUN: begin
                if (kind == K_READ_STAT) rdmode_d = 1'b1;
                reject_d = is_op || (kind == K_CLEAR) || (kind == K_ARRAY);
            end
            ST_LOCKED: begin
                if (kind == K_READ_STAT) rdmode_d = 1'b1;
                if (kind == K_ARRAY)     rdmode_d = 1'b0;
                reject_d = is_op;
            end
            default: ;
        endcase
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdmode_q <= 1'b0;
            reject_q <= 1'b0;
        end else begin
            rdmode_q <= rdmode_d;
            reject_q <= reject_d;
        end
    end

    always_comb begin
        stat_w = 8'h00;
        stat_w[STAT_READY_BIT] = (state_q != ST_RUN);
        stat_w[STAT_ERASE_BIT] = err_erase;
        stat_w[STAT_PROG_BIT]  = err_prog;
        stat_w[STAT_OVER_BIT]  = err_over;
    end

    assign status_out = rdmode_q ? stat_w : 8'h00;
    assign busy       = (state_q == ST_RUN);
    assign reject     = reject_q;

    // R8
    locked_matches_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED) == (err_erase || err_prog || err_over));

    // R8
    lockout_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && is_op) |=> (!busy && reject));

    // R3
    busy_from_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));

    // R9
    busy_clear_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !tmr_last && kind == K_CLEAR) |=> (busy && $stable(stat_w)));

    // R11
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_out & 8'h47) == 8'h00);

    // R12
    reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> $past(cmd_valid));

endmodule

// File: tb/flash_status_ctrl_test.sv
module flash_status_ctrl_test;

    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [7:0]       cmd_byte = 8'h00;
    logic [CNT_W-1:0] busy_cycles = '0;
    logic [1:0]       prog_result = 2'b00;
    logic [1:0]       erase_result = 2'b00;
    logic [7:0]       status_out;
    logic             busy;
    logic             reject;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    flash_status_ctrl #(.CNT_W(CNT_W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_byte     (cmd_byte),
        .busy_cycles  (busy_cycles),
        .prog_result  (prog_result),
        .erase_result (erase_result),
        .status_out   (status_out),
        .busy         (busy),
        .reject       (reject)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // drives at a falling edge; returns at the falling edge after the accepting rising edge
    task automatic send(input logic [7:0] code);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = code;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_byte  = 8'h00;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    function automatic logic [7:0] expect_final(input logic [7:0] op, input logic [1:0] res);
        if (op == 8'h41 || op == 8'h77) begin
            if (res == 2'b00) return 8'h80;
            if (res == 2'b10) return 8'h88;
            return 8'h90;
        end
        return res[0] ? 8'hA0 : 8'h80;
    endfunction

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=0x0 expected=0x1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] ops [4];
        int n;
        logic [7:0] exp_s;
        ops[0] = 8'h41; ops[1] = 8'h77; ops[2] = 8'h20; ops[3] = 8'hA7;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 status_out", status_out, 8'h00);
        check("R1 busy", busy, 0);
        check("R1 reject", reject, 0);
        rst_n = 1'b1;
        @(negedge clk);
        send(8'h70);
        check("R1 status after read", status_out, 8'h80);
        check("R2 reject on read", reject, 0);

        // R10 unknown code in idle
        send(8'h33);
        check("R10 status", status_out, 8'h80);
        check("R10 busy", busy, 0);
        check("R10 reject", reject, 0);

        // R2 leave read mode and re-enter
        send(8'hFF);
        check("R2 off", status_out, 8'h00);
        send(8'h70);
        check("R2 on", status_out, 8'h80);

        // sweep: op x result x length (R3 R4 R5 R6 R7 R8 R11 R12)
        for (int oi = 0; oi < 4; oi++) begin
            for (int r = 0; r < 4; r++) begin
                for (int len = 0; len < 6; len++) begin
                    busy_cycles  = CNT_W'(len);
                    prog_result  = 2'(r);
                    erase_result = 2'(r);
                    send(ops[oi]);
                    check("R3 busy at start", busy, 1);
                    check("R3 ready bit low", status_out, 8'h00);
                    check("R12 no reject on accept", reject, 0);
                    count_busy(n);
                    check("R3 busy length", n, (len == 0) ? 1 : len);
                    exp_s = expect_final(ops[oi], 2'(r));
                    check((oi < 2) ? "R4 final status" : "R5 final status", status_out, exp_s);
                    if (exp_s != 8'h80) begin
                        for (int k = 0; k < 4; k++) begin
                            send(ops[k]);
                            check("R8 refused busy", busy, 0);
                            check("R8 reject", reject, 1);
                            check("R8 status held", status_out, exp_s);
                            @(negedge clk);
                            check("R12 single pulse", reject, 0);
                        end
                        send(8'hFF);
                        send(8'h5A);
                        repeat (5) @(negedge clk);
                        send(8'h70);
                        check("R6 sticky", status_out, exp_s);
                        send(8'h50);
                        check("R7 cleared", status_out, 8'h80);
                    end
                end
            end
        end

        // R9 commands during a long operation
        busy_cycles = 4'd14;
        prog_result = 2'b01;
        send(8'h41);
        send(8'h50);
        check("R9 clear refused", reject, 1);
        check("R9 still busy", busy, 1);
        send(8'hFF);
        check("R9 array refused", reject, 1);
        check("R9 read mode kept", status_out, 8'h00);
        send(8'h20);
        check("R9 op refused", reject, 1);
        send(8'h33);
        check("R10 unknown while busy", reject, 0);
        count_busy(n);
        check("R9 final fail kept", status_out, 8'h90);
        send(8'h50);
        check("R7 clear after busy", status_out, 8'h80);

        // R2 read honoured while busy
        send(8'hFF);
        busy_cycles = 4'd6;
        prog_result = 2'b00;
        send(8'h41);
        check("R2 off while busy", status_out, 8'h00);
        send(8'h70);
        check("R2 read while busy", status_out, 8'h00);
        check("R9 read not rejected", reject, 0);
        count_busy(n);
        check("R2 final status", status_out, 8'h80);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule